// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Wrapping Converter

The block turns an IEEE-754 double into a 64-bit two's-complement integer without saturating. When the magnitude does not fit, the result is the low 64 bits of the exact integer. Software can therefore use the same operation for signed and for unsigned conversion. The block supports four rounding modes and reports five exception flags beside the result. A small variant code chooses between three behaviours:

- the dynamic rounding mode with exception reporting on;
- forced truncation with reporting off;
- forced truncation with reporting on.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. One output register sits between the two streams. An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result appears in the next cycle. A result remains on the output, unchanged, until a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so the block sustains one result per cycle under full flow.

The flags go to a separate trap-reporting unit. The block itself raises no traps.

Top module: `f64_wrap_cvt`

## Requirements
- R1: A finite operand whose value is an integer in range converts exactly, and its flags are 0. Flag vector bits are: [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact.
- R2: When the unbiased exponent is at least 52, the result is the significand (with its hidden bit) shifted left, truncated to 64 bits. Overflow is set, if reporting is on, when bits are lost in that shift. When the left shift would be 63 or more, the result is 0 with no flag.
- R3: In mode 0 (nearest-even), discarded bits above one half round the magnitude up. Exactly one half rounds the magnitude up only when its low bit is 1.
- R4: Mode 1 (down) adds one to the magnitude of a negative inexact value. Mode 2 (up) adds one to the magnitude of a positive inexact value. Mode 3 (toward zero) only truncates.
- R5: Inexact is set, if reporting is on, whenever discarded bits are nonzero. Denormals, and values smaller than 2^-63 in magnitude, count as magnitude 0 with nonzero discarded bits.
- R6: A negative operand yields the two's-complement negation of its rounded magnitude.
- R7: Positive and negative zero give result 0 and no flags.
- R8: A NaN gives 0 with invalid set, whatever the variant. An infinity gives 0, with overflow set only when reporting is on.
- R9: Variant 0 uses the `dyn_mode` input with reporting on. Variant 1 truncates with reporting off. Variants 2 and 3 truncate with reporting on. In variants 1 to 3, `dyn_mode` is ignored.
- R10: The divide-by-zero and underflow flags are always 0.
- R11: A result is due on the cycle after acceptance. It stays stable while `out_valid` is high and `out_ready` is low, and `in_ready` is low during such a stall.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be taken |
| in_bits | input | 64 | Double-precision operand |
| in_variant | input | 2 | Variant code (R9) |
| dyn_mode | input | 2 | Dynamic rounding mode: 0 nearest-even, 1 down, 2 up, 3 toward zero |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_int | output | 64 | Integer result |
| out_flags | output | 5 | Exception flags (R1 bit order) |

## Verification
Every result is due exactly one rising edge after its operand is accepted. It is read on the falling edge after that, and it is consumed at the next rising edge where `out_ready` is high. The driver records each expected result in order, and the monitor compares a result only on a falling edge where `out_valid` and `out_ready` are both high, so stalled cycles never consume an expected item. While the consumer is stalled, the monitor checks on each falling edge that the held result has not moved and that `in_ready` is low.

// File: rtl/f64cvt_pkg.sv
package f64cvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  localparam int FLG_W   = 5;
  localparam int FLG_INV = 0;
  localparam int FLG_DZE = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_INE = 4;
endpackage

// File: rtl/f64cvt_ctrl.sv
module f64cvt_ctrl
  import f64cvt_pkg::*;
(
  input  logic [1:0] variant,
  input  logic [1:0] dyn_mode,
  output rmode_e     mode,
  output logic       exc_en
);
  always_comb begin
    unique case (variant)
      2'd0: begin mode = rmode_e'(dyn_mode); exc_en = 1'b1; end
      2'd1: begin mode = RM_ZERO;            exc_en = 1'b0; end
      default: begin mode = RM_ZERO;         exc_en = 1'b1; end
    endcase
  end
endmodule

// File: rtl/f64cvt_align.sv
module f64cvt_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic [EXP_W+FRAC_W:0] bits,
  output logic                  sign,
  output logic [INT_W-1:0]      mag,
  output logic [INT_W-1:0]      rnd,
  output logic                  lost_hi,
  output logic                  is_nan,
  output logic                  is_inf
);
  localparam int SW   = EXP_W + 2;
  localparam int AW   = $clog2(INT_W);
  localparam int OFS  = (1 << (EXP_W - 1)) - 1 + FRAC_W;
  localparam logic signed [SW-1:0] OFS_S = SW'(OFS);
  localparam logic signed [SW-1:0] LIM_S = SW'(INT_W - 1);

  logic [EXP_W-1:0]     expo;
  logic [FRAC_W-1:0]    frac;
  logic [INT_W-1:0]     mant;
  logic signed [SW-1:0] sh;
  logic signed [SW-1:0] nsh;
  logic [AW-1:0]        amt;
  logic [AW-1:0]        lsh;

  assign sign = bits[EXP_W+FRAC_W];
  assign expo = bits[EXP_W+FRAC_W-1:FRAC_W];
  assign frac = bits[FRAC_W-1:0];
  assign mant = {{(INT_W-FRAC_W-1){1'b0}}, 1'b1, frac};
  assign sh   = $signed({2'b00, expo}) - OFS_S;
  assign nsh  = -sh;

  always_comb begin
    mag     = '0;
    rnd     = '0;
    lost_hi = 1'b0;
    is_nan  = 1'b0;
    is_inf  = 1'b0;
    amt     = '0;
    lsh     = '0;
    if (expo == '0) begin
      if (frac != '0) rnd = INT_W'(1);
    end else if (expo == '1) begin
      is_nan = (frac != '0);
      is_inf = (frac == '0);
    end else if (!sh[SW-1]) begin
      if (sh < LIM_S) begin
        amt     = sh[AW-1:0];
        mag     = mant << amt;
        lost_hi = ((mag >> amt) != mant);
      end
    end else begin
      if (nsh < LIM_S) begin
        amt = nsh[AW-1:0];
        lsh = AW'(0) - amt;
        mag = mant >> amt;
        rnd = mant << lsh;
      end else begin
        rnd = INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/f64cvt_round.sv
module f64cvt_round
  import f64cvt_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic [INT_W-1:0] rnd,
  output logic [INT_W-1:0] result
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic             inc;
  logic [INT_W-1:0] sum;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = (rnd > HALF) || ((rnd == HALF) && mag[0]);
      RM_DOWN: inc = sign && (rnd != '0);
      RM_UP:   inc = !sign && (rnd != '0);
      default: inc = 1'b0;
    endcase
  end

  assign sum    = mag + INT_W'(inc);
  assign result = sign ? (~sum + INT_W'(1)) : sum;
endmodule

// File: rtl/f64_wrap_cvt.sv
module f64_wrap_cvt
  import f64cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+FRAC_W:0] in_bits,
  input  logic [1:0]            in_variant,
  input  logic [1:0]            dyn_mode,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [INT_W-1:0]      out_int,
  output logic [FLG_W-1:0]      out_flags
);
  rmode_e             mode;
  logic               exc_en;
  logic               sign;
  logic [INT_W-1:0]   mag;
  logic [INT_W-1:0]   rnd;
  logic               lost_hi;
  logic               is_nan;
  logic               is_inf;
  logic [INT_W-1:0]   result;
  logic [FLG_W-1:0]   flags;
  logic               take;

  f64cvt_ctrl u_ctrl (
    .variant (in_variant),
    .dyn_mode(dyn_mode),
    .mode    (mode),
    .exc_en  (exc_en)
  );

  f64cvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .bits   (in_bits),
    .sign   (sign),
    .mag    (mag),
    .rnd    (rnd),
    .lost_hi(lost_hi),
    .is_nan (is_nan),
    .is_inf (is_inf)
  );

  f64cvt_round #(.INT_W(INT_W)) u_round (
    .mode  (mode),
    .sign  (sign),
    .mag   (mag),
    .rnd   (rnd),
    .result(result)
  );

  always_comb begin
    flags          = '0;
    flags[FLG_INV] = is_nan;
    flags[FLG_OVF] = exc_en && (lost_hi || is_inf);
    flags[FLG_INE] = exc_en && (rnd != '0);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_int   <= result;
        out_flags <= flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/f64_wrap_cvt_chk.sv
module f64_wrap_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_bits,
  input logic [1:0]  in_variant,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_int,
  input logic [4:0]  out_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int) && $stable(out_flags)));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_bits[62:52] == 11'h7ff) && (in_bits[51:0] != '0))
      |=> (out_flags[0] && (out_int == '0)));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_variant == 2'd1)) |=> (!out_flags[2] && !out_flags[4]));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_bits[62:0] == '0)) |=> ((out_int == '0) && (out_flags == '0)));
endmodule

bind f64_wrap_cvt f64_wrap_cvt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bits   (in_bits),
  .in_variant(in_variant),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_int   (out_int),
  .out_flags (out_flags)
);

// File: tb/test_f64_wrap_cvt.sv
module test_f64_wrap_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_bits = '0;
  logic [1:0]  in_variant = '0;
  logic [1:0]  dyn_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_int;
  logic [4:0]  out_flags;

  localparam logic [4:0] F_INV = 5'h01;
  localparam logic [4:0] F_OVF = 5'h04;
  localparam logic [4:0] F_INE = 5'h10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct {
    logic [63:0] v;
    logic [4:0]  f;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   stall_mode = 1'b0;
  bit   done = 1'b0;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_int;
  logic [4:0]  prev_flags;

  always #10 clk = ~clk;

  f64_wrap_cvt i_f64_wrap_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_variant(in_variant), .dyn_mode(dyn_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] b, input logic [1:0] var_c, input logic [1:0] m,
                      input logic [63:0] ev, input logic [4:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid   = 1'b1;
    in_bits    = b;
    in_variant = var_c;
    dyn_mode   = m;
    while (!in_ready) @(negedge clk);
    e.v = ev; e.f = ef; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = !stall_mode || (cyc % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        chk(out_valid && out_int == prev_int && out_flags == prev_flags,
            "R11 held", out_int, prev_int);
        chk(!in_ready || out_ready, "R11 in_ready", {63'd0, in_ready}, {63'd0, out_ready});
      end
      prev_stall = out_valid && !out_ready;
      prev_int   = out_int;
      prev_flags = out_flags;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 extra", out_int, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_int == e.v, {e.tag, " value"}, out_int, e.v);
          chk(out_flags == e.f, {e.tag, " flags"}, {59'd0, out_flags}, {59'd0, e.f});
        end
      end
    end
  end

  task automatic run_vectors();
    send(64'h3FF0_0000_0000_0000, 2'd0, 2'd0, 64'd1,   5'h00, "R1 one");
    send(64'h4059_0000_0000_0000, 2'd0, 2'd0, 64'd100, 5'h00, "R1 hundred");
    send(64'hBFF0_0000_0000_0000, 2'd0, 2'd0, ONES,    5'h00, "R6 minus one");
    send(64'h4004_0000_0000_0000, 2'd0, 2'd0, 64'd2,   F_INE, "R3 2.5 even");
    send(64'h400C_0000_0000_0000, 2'd0, 2'd0, 64'd4,   F_INE, "R3 3.5 even");
    send(64'h4006_0000_0000_0000, 2'd0, 2'd0, 64'd3,   F_INE, "R3 2.75 above half");
    send(64'h4004_0000_0000_0000, 2'd0, 2'd2, 64'd3,   F_INE, "R4 up pos");
    send(64'h4004_0000_0000_0000, 2'd0, 2'd1, 64'd2,   F_INE, "R4 down pos");
    send(64'hC004_0000_0000_0000, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFD, F_INE, "R4 R6 down neg");
    send(64'hC004_0000_0000_0000, 2'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFE, F_INE, "R4 R6 up neg");
    send(64'h4006_0000_0000_0000, 2'd0, 2'd3, 64'd2,   F_INE, "R4 zero mode");
    send(64'h4006_0000_0000_0000, 2'd1, 2'd0, 64'd2,   5'h00, "R9 variant1");
    send(64'h4004_0000_0000_0000, 2'd2, 2'd2, 64'd2,   F_INE, "R9 variant2");
    send(64'h4006_0000_0000_0000, 2'd3, 2'd0, 64'd2,   F_INE, "R9 variant3");
    send(64'h43E0_0000_0000_0000, 2'd0, 2'd0, 64'h8000_0000_0000_0000, 5'h00, "R2 two63");
    send(64'h43F0_0000_0000_0001, 2'd0, 2'd0, 64'h0000_0000_0000_1000, F_OVF, "R2 wrap");
    send(64'h43F0_0000_0000_0000, 2'd1, 2'd0, 64'd0,   5'h00, "R2 wrap quiet");
    send(64'h7E70_0000_0000_0000, 2'd0, 2'd0, 64'd0,   5'h00, "R2 huge");
    send(64'h7FF8_0000_0000_0000, 2'd1, 2'd0, 64'd0,   F_INV, "R8 nan");
    send(64'h7FF0_0000_0000_0000, 2'd0, 2'd0, 64'd0,   F_OVF, "R8 inf");
    send(64'hFFF0_0000_0000_0000, 2'd1, 2'd0, 64'd0,   5'h00, "R8 inf quiet");
    send(64'h0000_0000_0000_0001, 2'd0, 2'd2, 64'd1,   F_INE, "R5 R10 denorm up");
    send(64'h8000_0000_0000_0001, 2'd0, 2'd1, ONES,    F_INE, "R5 R10 denorm down");
    send(64'h39B0_0000_0000_0000, 2'd0, 2'd0, 64'd0,   F_INE, "R5 tiny");
    send(64'h39B0_0000_0000_0000, 2'd1, 2'd0, 64'd0,   5'h00, "R5 tiny quiet");
    send(64'h0000_0000_0000_0000, 2'd0, 2'd0, 64'd0,   5'h00, "R7 pos zero");
    send(64'h8000_0000_0000_0000, 2'd0, 2'd1, 64'd0,   5'h00, "R7 neg zero");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 out_valid", {63'd0, out_valid}, 64'd0);
    chk(in_ready == 1'b1, "R12 in_ready", {63'd0, in_ready}, 64'd1);
    run_vectors();
    stall_mode = 1'b1;
    run_vectors();
    stall_mode = 1'b0;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R11 drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    done = 1'b1;
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=%0d expected<%0d", cyc, 20000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule